// File: doc/BRIEF.md
# Eight-Bit Multi-Function Arithmetic Logic Unit

This block is the arithmetic-logic unit of a small 8-bit processor core. It accepts a 6-bit operation code and two 8-bit operands, called A and B, and returns one 8-bit result. The block has no clock and no register stage, so the result is valid in the same cycle that the inputs change.

The supported operations are:

- Bitwise logic: invert, AND, OR and XOR.
- Single-operand reductions on A: parity and population count.
- A pass-through of B.
- Logical shifts of A by a variable amount.
- Modulo-256 add and subtract.
- Three comparisons that set bit 0 of the result.

Operation codes are sparse. Any code that does not name an operation produces an all-zero result.

Internally, a decoder turns the operation code into a packed set of one-bit strobes. A datapath computes every candidate value and selects one of them with those strobes. Compare and subtract share one adder chain. Left and right shifts share one barrel network.

Top module: `alu8`

## Requirements
- R1: The result is purely combinational. It follows any change of opCode, opA or opB without a clock edge.
- R2: Code 000000 returns the bitwise inverse of opA.
- R3: Code 000100 returns the XOR of all eight bits of opA in bit 0, with bits 7..1 cleared.
- R4: Code 001000 returns the number of 1 bits in opA as an unsigned value from 0 to 8.
- R5: Codes 001101, 010001 and 010101 return opA AND opB, opA OR opB and opA XOR opB respectively.
- R6: Code 011001 returns opB unchanged.
- R7: Code 011101 shifts opA left logically by the unsigned value of opB. Any amount of 8 or more gives 0x00.
- R8: Code 100001 shifts opA right logically by the unsigned value of opB. Any amount of 8 or more gives 0x00.
- R9: Code 000010 returns (opA + opB) mod 256.
- R10: Code 000110 returns (opA - opB) mod 256.
- R11: Code 000011 returns 0x01 when opA equals opB and 0x00 otherwise.
- R12: Code 000111 returns 0x01 when opA is less than opB as two's-complement values, and 0x00 otherwise.
- R13: Code 001011 returns 0x01 when opA is less than opB as unsigned values, and 0x00 otherwise.
- R14: Every 6-bit code not listed in R2 to R13 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opCode | input | 6 | Operation select code |
| opA | input | 8 | First operand; the only source for the unary operations and the shifted value |
| opB | input | 8 | Second operand; also the shift amount and the pass-through source |
| result | output | 8 | Combinational result |

## Verification
**Checked by the assertions on every evaluation.** The assertions check that the decoded strobes are never active more than one at a time. They also check that:
- any undecoded code gives zero;
- the compare and parity results never set bits above bit 0;
- an out-of-range shift amount gives zero;
- the pass-through returns B;
- the population count never exceeds eight.

**Shown only by the bench's scenarios.** The exact arithmetic needs the bench, which sweeps every 6-bit code over a grid of corner operands and then over random operands. This covers:
- wrap-around of the add and the subtract;
- the signed and unsigned orderings, including across 0x7F/0x80;
- shift amounts of 0, 7 and 8.

The same-cycle behaviour is shown by sampling the result with no clock edge between the input change and the check.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int OP_W = 6;

  typedef enum logic [OP_W-1:0] {
    OP_INV  = 6'b000000,
    OP_ADD  = 6'b000010,
    OP_SEQ  = 6'b000011,
    OP_PAR  = 6'b000100,
    OP_SUB  = 6'b000110,
    OP_SLT  = 6'b000111,
    OP_CNT  = 6'b001000,
    OP_SLTU = 6'b001011,
    OP_AND  = 6'b001101,
    OP_OR   = 6'b010001,
    OP_XOR  = 6'b010101,
    OP_MOV  = 6'b011001,
    OP_SHL  = 6'b011101,
    OP_SHR  = 6'b100001
  } aluOp_e;

  // One strobe per result source; at most one is high.
  typedef struct packed {
    logic inv;
    logic par;
    logic cnt;
    logic andOp;
    logic orOp;
    logic xorOp;
    logic mov;
    logic shl;
    logic shr;
    logic add;
    logic sub;
    logic seq;
    logic slt;
    logic sltu;
  } aluStrobe_t;

endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  output aluStrobe_t      strobe
);

  always_comb begin
    strobe = '0;
    case (opCode)
      OP_INV:  strobe.inv   = 1'b1;
      OP_PAR:  strobe.par   = 1'b1;
      OP_CNT:  strobe.cnt   = 1'b1;
      OP_AND:  strobe.andOp = 1'b1;
      OP_OR:   strobe.orOp  = 1'b1;
      OP_XOR:  strobe.xorOp = 1'b1;
      OP_MOV:  strobe.mov   = 1'b1;
      OP_SHL:  strobe.shl   = 1'b1;
      OP_SHR:  strobe.shr   = 1'b1;
      OP_ADD:  strobe.add   = 1'b1;
      OP_SUB:  strobe.sub   = 1'b1;
      OP_SEQ:  strobe.seq   = 1'b1;
      OP_SLT:  strobe.slt   = 1'b1;
      OP_SLTU: strobe.sltu  = 1'b1;
      default: strobe = '0;
    endcase
  end

endmodule

// File: rtl/alu8_dp.sv
module alu8_dp
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  aluStrobe_t        strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result
);

  localparam int SH_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int MSB   = DATA_W - 1;

  // Shared subtractor: A + ~B + 1, carry out means A >= B unsigned.
  logic [DATA_W:0]   diffFull;
  logic [DATA_W-1:0] sumVal;
  logic              unsignedLt;
  logic              signedOvf;
  logic              signedLt;
  logic              isEqual;

  assign diffFull   = {1'b0, opA} + {1'b0, ~opB} + (DATA_W+1)'(1);
  assign sumVal     = opA + opB;
  assign unsignedLt = ~diffFull[DATA_W];
  assign signedOvf  = (opA[MSB] ^ opB[MSB]) & (opA[MSB] ^ diffFull[MSB]);
  assign signedLt   = diffFull[MSB] ^ signedOvf;
  assign isEqual    = (diffFull[DATA_W-1:0] == '0);

  // Reductions on A.
  logic [CNT_W-1:0] onesCount;
  logic             parityBit;

  always_comb begin
    onesCount = '0;
    for (int i = 0; i < DATA_W; i++) begin
      onesCount = onesCount + CNT_W'(opA[i]);
    end
  end

  assign parityBit = ^opA;

  // Single right-shifting barrel; left shifts reverse in and out.
  logic [DATA_W-1:0] revA;
  logic [DATA_W-1:0] shIn;
  logic [DATA_W-1:0] stage [0:SH_W];
  logic [DATA_W-1:0] revOut;
  logic              overRange;

  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
      assign revA[i]   = opA[MSB-i];
      assign revOut[i] = stage[SH_W][MSB-i];
    end
  endgenerate

  assign shIn     = strobe.shl ? revA : opA;
  assign stage[0] = shIn;

  generate
    for (genvar k = 0; k < SH_W; k++) begin : g_shift
      assign stage[k+1] = opB[k] ? (stage[k] >> (1 << k)) : stage[k];
    end
  endgenerate

  assign overRange = ({1'b0, opB} >= (DATA_W+1)'(DATA_W));

  logic [DATA_W-1:0] shlVal;
  logic [DATA_W-1:0] shrVal;

  assign shlVal = overRange ? '0 : revOut;
  assign shrVal = overRange ? '0 : stage[SH_W];

  // AND-OR selection driven by the strobes.
  always_comb begin
    result = ({DATA_W{strobe.inv}}   & ~opA)
           | ({DATA_W{strobe.par}}   & DATA_W'(parityBit))
           | ({DATA_W{strobe.cnt}}   & DATA_W'(onesCount))
           | ({DATA_W{strobe.andOp}} & (opA & opB))
           | ({DATA_W{strobe.orOp}}  & (opA | opB))
           | ({DATA_W{strobe.xorOp}} & (opA ^ opB))
           | ({DATA_W{strobe.mov}}   & opB)
           | ({DATA_W{strobe.shl}}   & shlVal)
           | ({DATA_W{strobe.shr}}   & shrVal)
           | ({DATA_W{strobe.add}}   & sumVal)
           | ({DATA_W{strobe.sub}}   & diffFull[DATA_W-1:0])
           | ({DATA_W{strobe.seq}}   & DATA_W'(isEqual))
           | ({DATA_W{strobe.slt}}   & DATA_W'(signedLt))
           | ({DATA_W{strobe.sltu}}  & DATA_W'(unsignedLt));
  end

endmodule

// File: rtl/alu8.sv
module alu8
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result
);

  aluStrobe_t strobe;

  alu8_ctrl u_ctrl (
    .opCode (opCode),
    .strobe (strobe)
  );

  alu8_dp #(.DATA_W(DATA_W)) u_dp (
    .strobe (strobe),
    .opA    (opA),
    .opB    (opB),
    .result (result)
  );

endmodule

// File: rtl/alu8_chk.sv
module alu8_chk
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic [OP_W-1:0]   opCode,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [DATA_W-1:0] result,
  input aluStrobe_t        strobe
);

  always_comb begin
    // R14
    strobe_onehot_chk: assert ($onehot0(strobe))
      else $error("more than one strobe active");

    // R14
    unknown_zero_chk: assert (strobe != '0 || result == '0)
      else $error("undecoded code gave nonzero result");

    // R11 R12 R13
    cmp_bit0_chk: assert (!(opCode == OP_SEQ || opCode == OP_SLT || opCode == OP_SLTU)
                          || result[DATA_W-1:1] == '0)
      else $error("compare result wider than one bit");

    // R3
    parity_chk: assert (opCode != OP_PAR
                        || (result[DATA_W-1:1] == '0 && result[0] == ^opA))
      else $error("parity result wrong");

    // R7 R8
    shift_range_chk: assert (!((opCode == OP_SHL || opCode == OP_SHR)
                               && int'(opB) >= DATA_W) || result == '0)
      else $error("out-of-range shift not zero");

    // R6
    move_chk: assert (opCode != OP_MOV || result == opB)
      else $error("move did not pass B");

    // R4
    count_range_chk: assert (opCode != OP_CNT || int'(result) <= DATA_W)
      else $error("bit count above width");
  end

endmodule

bind alu8 alu8_chk #(.DATA_W(DATA_W)) u_chk (
  .opCode (opCode),
  .opA    (opA),
  .opB    (opB),
  .result (result),
  .strobe (strobe)
);

// File: tb/tb_alu8.sv
module tb_alu8;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic [5:0] opCode = 6'b111111;
  logic [7:0] opA = '0;
  logic [7:0] opB = '0;
  logic [7:0] result;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  int cycles = 0;

  alu8 dut (
    .opCode (opCode),
    .opA    (opA),
    .opB    (opB),
    .result (result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] refModel(logic [5:0] op, logic [7:0] x, logic [7:0] y);
    int ux = x;
    int uy = y;
    int sx = $signed(x);
    int sy = $signed(y);
    int ones = 0;
    int r;
    for (int i = 0; i < 8; i++) ones += x[i];
    case (op)
      6'b000000: r = 255 - ux;
      6'b000100: r = ones % 2;
      6'b001000: r = ones;
      6'b001101: r = ux & uy;
      6'b010001: r = ux | uy;
      6'b010101: r = ux ^ uy;
      6'b011001: r = uy;
      6'b011101: r = (uy >= 8) ? 0 : (ux * (2 ** uy)) % 256;
      6'b100001: r = (uy >= 8) ? 0 : ux / (2 ** uy);
      6'b000010: r = (ux + uy) % 256;
      6'b000110: r = (ux - uy + 256) % 256;
      6'b000011: r = (ux == uy) ? 1 : 0;
      6'b000111: r = (sx < sy) ? 1 : 0;
      6'b001011: r = (ux < uy) ? 1 : 0;
      default:   r = 0;
    endcase
    return r[7:0];
  endfunction

  function automatic string reqTag(logic [5:0] op);
    case (op)
      6'b000000: return "R2";
      6'b000100: return "R3";
      6'b001000: return "R4";
      6'b001101, 6'b010001, 6'b010101: return "R5";
      6'b011001: return "R6";
      6'b011101: return "R7";
      6'b100001: return "R8";
      6'b000010: return "R9";
      6'b000110: return "R10";
      6'b000011: return "R11";
      6'b000111: return "R12";
      6'b001011: return "R13";
      default:   return "R14";
    endcase
  endfunction

  task automatic compare(string tag, logic [7:0] expVal);
    checks++;
    if (result !== expVal) begin
      errors++;
      $display("FAIL %s op=%b a=%02h b=%02h actual=%02h expected=%02h",
               tag, opCode, opA, opB, result, expVal);
    end
  endtask

  // Drive just after a rising edge, check at the following falling edge.
  task automatic applyCheck(logic [5:0] op, logic [7:0] x, logic [7:0] y);
    @(posedge clk);
    #1;
    opCode = op;
    opA    = x;
    opB    = y;
    @(negedge clk);
    compare(reqTag(op), refModel(op, x, y));
  endtask

  // R1: change inputs and sample with no clock edge in between.
  task automatic combCheck(logic [5:0] op, logic [7:0] x, logic [7:0] y);
    @(negedge clk);
    #1;
    opCode = op;
    opA    = x;
    opB    = y;
    #1;
    compare("R1", refModel(op, x, y));
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    logic [7:0] corners [8];
    corners = '{8'h00, 8'hFF, 8'h80, 8'h7F, 8'h01, 8'h03, 8'h14, 8'h08};

    // Start-up state: unknown code 111111 with zero operands must give zero (R14).
    #1;
    compare("R14", 8'h00);

    // Same-cycle response (R1).
    combCheck(6'b000000, 8'h03, 8'h14);
    combCheck(6'b000010, 8'hF0, 8'h20);
    combCheck(6'b000111, 8'h03, 8'h14);
    combCheck(6'b011101, 8'h81, 8'h01);

    // Spot values: a=3, b=20 (R11 R12 R13 R3).
    applyCheck(6'b000011, 8'd3, 8'd20);
    applyCheck(6'b000111, 8'd3, 8'd20);
    applyCheck(6'b001011, 8'd3, 8'd20);
    applyCheck(6'b000100, 8'd3, 8'd20);

    // Shift amounts 0, 7, 8, 255 (R7 R8).
    for (int s = 0; s < 4; s++) begin
      logic [7:0] amt;
      amt = (s == 0) ? 8'd0 : (s == 1) ? 8'd7 : (s == 2) ? 8'd8 : 8'd255;
      applyCheck(6'b011101, 8'hA5, amt);
      applyCheck(6'b100001, 8'hA5, amt);
    end

    // Every code over the corner grid (R2..R14).
    for (int op = 0; op < 64; op++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          applyCheck(6'(op), corners[i], corners[j]);
        end
      end
    end

    // Random operands on random codes.
    for (int n = 0; n < 1500; n++) begin
      applyCheck(6'($urandom_range(63)), 8'($urandom), 8'($urandom));
    end

    finishRun();
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
      finishRun();
    end
  end

endmodule